// File: doc/BRIEF.md
# Memory Map Decoder with Access Trap

This block sits on the processor's address phase and sorts every access into one of three targets: read-only program memory, read-write data memory, or a 256-byte window of on-chip control registers. An access that lands in none of them raises a trap in the same cycle. The decoded sizes of program and data memory are not fixed. Two 3-bit size fields in a configuration register set them, and after reset both start at their smallest setting. Boot code must widen them before it touches memory above the small default span.

The register window holds a control register, the size configuration register, a wait-state register and two write-protection window registers. When the protection bit in the control register is set, a data-memory write is allowed only if it falls inside at least one of the two windows. Any other write traps. Every other word offset in the register window works as plain scratch storage. A write there is kept and can be read back. It never traps and changes nothing else.

Select and trap outputs are purely combinational on the request. A read of the register window returns its data on the cycle after the request.

Top module: `memMapDecoder`

## Requirements
- R1: Program memory is selected when the byte address is below 4 KB shifted left by PSIZ, where PSIZ is bits [2:0] of the configuration register at offset 0x10. The span is clamped to 512 KB, so any address at or above 0x00080000 never selects it.
- R2: Data memory is selected when the address is at or above 0x02000000 and its distance from that base is below 256 KB shifted left by RSIZ, where RSIZ is bits [6:4] of the configuration register. The span is clamped to 4 MB, ending below 0x02400000.
- R3: After reset the decoded spans are 4 KB of program memory (0x0 to 0xFFF) and 256 KB of data memory (0x02000000 to 0x0203FFFF).
- R4: Addresses 0x01F80000 through 0x01F800FF select the register window, and such an access never traps.
- R5: The three selects are active only while a request is valid and at most one is active at a time. A valid request that selects none of them raises the trap in the same cycle, and with no valid request there is no trap.
- R6: A register-window read sets the read-valid output for exactly the next cycle, with the data of the addressed word as it stood before that clock edge. A register write takes effect at that edge.
- R7: The control register at offset 0x00 keeps only bit 0 (power-down enable), bit 1 (soft-reset enable) and bit 3 (protection enable). The other bits read back as zero.
- R8: The configuration (0x10), wait-state (0x18) and two protection window registers (0x20, 0x24) read back all 32 written bits.
- R9: Every other word offset in the register window stores the written value for read-back. It raises no trap and does not change decoding or protection.
- R10: When protection is enabled, a data-memory write traps unless its 64-byte block index, meaning bits [21:6] of the offset from 0x02000000, lies between a window's start in bits [15:0] and its end in bits [31:16] inclusive, for at least one of the two windows. Data-memory reads and unprotected writes never trap.
- R11: Reset clears every register and scratch word to zero and clears read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Access request present this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 32 | Byte address of the access |
| busWdata | input | 32 | Write data for register-window writes |
| selRom | output | 1 | Program memory selected |
| selRam | output | 1 | Data memory selected |
| selRegs | output | 1 | Register window selected |
| accessTrap | output | 1 | Memory exception for this access |
| rdValid | output | 1 | Register read data valid (one cycle after request) |
| rdData | output | 32 | Register read data |

## Verification
The bench probes the last byte inside each decoded span and the first byte past it. It does this at the reset sizes, at a mid setting and at the clamped maximum. An off-by-one limit or a missing clamp would then select memory that should trap, or trap inside a legal span. It checks that scratch writes read back and leave decoding untouched, and that the control register drops its unused bits. It tests protection on the first and last block of each window and on the blocks just outside them. It also checks that reads and protection-off writes go through, which catches an inverted bound or a write-only check applied to reads. A long sweep of mixed accesses, some of which reprogram the registers, is compared on every cycle against a behavioural model.

// File: rtl/memMapPkg.sv
package memMapPkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;   // word index inside the 256-byte register window
  localparam int LOG_W  = 6;   // width of region size exponents

  // Word indices of the implemented registers
  localparam logic [IDX_W-1:0] CTRL_IDX = 6'd0;   // offset 0x00
  localparam logic [IDX_W-1:0] CFG_IDX  = 6'd4;   // offset 0x10
  localparam logic [IDX_W-1:0] WAIT_IDX = 6'd6;   // offset 0x18
  localparam int               ACC_IDX  = 8;      // offset 0x20, windows follow word by word

  // Strobes handed from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;

endpackage

// File: rtl/memMapCtrl.sv
module memMapCtrl
  import memMapPkg::*;
(
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [IDX_W-1:0] regIdx,
  input  logic             romHit,
  input  logic             ramHit,
  input  logic             regHit,
  input  logic             protOn,
  input  logic             winAllowed,
  output logic             selRom,
  output logic             selRam,
  output logic             selRegs,
  output logic             accessTrap,
  output regStrobe_t       strobe
);

  logic anyHit;
  logic protFault;

  always_comb begin
    anyHit    = romHit | ramHit | regHit;
    protFault = ramHit & busWrite & protOn & ~winAllowed;

    selRom     = busValid & romHit;
    selRam     = busValid & ramHit;
    selRegs    = busValid & regHit;
    accessTrap = busValid & (~anyHit | protFault);

    strobe.wrEn = busValid & regHit & busWrite;
    strobe.rdEn = busValid & regHit & ~busWrite;
    strobe.idx  = regIdx;
  end

endmodule

// File: rtl/memMapData.sv
module memMapData
  import memMapPkg::*;
#(
  parameter int                ROM_MIN_LOG2 = 12,
  parameter int                ROM_MAX_LOG2 = 19,
  parameter logic [ADDR_W-1:0] RAM_BASE     = 32'h0200_0000,
  parameter int                RAM_MIN_LOG2 = 18,
  parameter int                RAM_MAX_LOG2 = 22,
  parameter logic [ADDR_W-1:0] REG_BASE     = 32'h01F8_0000,
  parameter int                BLK_LOG2     = 6,
  parameter int                NUM_WIN      = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  regStrobe_t        strobe,
  output logic              romHit,
  output logic              ramHit,
  output logic              regHit,
  output logic              protOn,
  output logic              winAllowed,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int REG_LOG2  = IDX_W + 2;
  localparam int WIN_W     = DATA_W / 2;
  localparam int SCR_DEPTH = 1 << IDX_W;

  logic [3:0]        ctrlReg;
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] waitReg;
  logic [DATA_W-1:0] accReg  [NUM_WIN];
  logic [DATA_W-1:0] scratch [SCR_DEPTH];

  logic [2:0]        psiz;
  logic [2:0]        rsiz;
  logic [LOG_W-1:0]  romLogRaw, romLog;
  logic [LOG_W-1:0]  ramLogRaw, ramLog;
  logic [ADDR_W-1:0] ramOff;
  logic [WIN_W-1:0]  blkIdx;
  logic [NUM_WIN-1:0] inWin;
  logic [DATA_W-1:0] accRd;
  logic [DATA_W-1:0] readMux;

  // ---------------- region decode ----------------
  always_comb begin
    psiz      = cfgReg[2:0];
    rsiz      = cfgReg[6:4];
    romLogRaw = LOG_W'(ROM_MIN_LOG2) + LOG_W'(psiz);
    ramLogRaw = LOG_W'(RAM_MIN_LOG2) + LOG_W'(rsiz);
    romLog    = (romLogRaw > LOG_W'(ROM_MAX_LOG2)) ? LOG_W'(ROM_MAX_LOG2) : romLogRaw;
    ramLog    = (ramLogRaw > LOG_W'(RAM_MAX_LOG2)) ? LOG_W'(RAM_MAX_LOG2) : ramLogRaw;

    ramOff = busAddr - RAM_BASE;
    romHit = (busAddr >> romLog) == '0;
    ramHit = (ramOff >> ramLog) == '0;
    regHit = busAddr[ADDR_W-1:REG_LOG2] == REG_BASE[ADDR_W-1:REG_LOG2];

    blkIdx = ramOff[BLK_LOG2 +: WIN_W];
    protOn = ctrlReg[3];
  end

  // ---------------- protection windows ----------------
  for (genvar gw = 0; gw < NUM_WIN; gw++) begin : gWin
    assign inWin[gw] = (blkIdx >= accReg[gw][WIN_W-1:0]) &&
                       (blkIdx <= accReg[gw][DATA_W-1:WIN_W]);
  end
  assign winAllowed = |inWin;

  // ---------------- implemented registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cfgReg  <= '0;
      waitReg <= '0;
      for (int w = 0; w < NUM_WIN; w++) accReg[w] <= '0;
    end else if (strobe.wrEn) begin
      if (strobe.idx == CTRL_IDX) ctrlReg <= {busWdata[3], 1'b0, busWdata[1:0]};
      if (strobe.idx == CFG_IDX)  cfgReg  <= busWdata;
      if (strobe.idx == WAIT_IDX) waitReg <= busWdata;
      for (int w = 0; w < NUM_WIN; w++)
        if (strobe.idx == IDX_W'(ACC_IDX + w)) accReg[w] <= busWdata;
    end
  end

  // ---------------- scratch storage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SCR_DEPTH; s++) scratch[s] <= '0;
    end else if (strobe.wrEn) begin
      scratch[strobe.idx] <= busWdata;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    accRd = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (strobe.idx == IDX_W'(ACC_IDX + w)) accRd = accReg[w];
  end

  always_comb begin
    if (strobe.idx == CTRL_IDX)
      readMux = {{(DATA_W-4){1'b0}}, ctrlReg};
    else if (strobe.idx == CFG_IDX)
      readMux = cfgReg;
    else if (strobe.idx == WAIT_IDX)
      readMux = waitReg;
    else if (strobe.idx >= IDX_W'(ACC_IDX) && strobe.idx < IDX_W'(ACC_IDX + NUM_WIN))
      readMux = accRd;
    else
      readMux = scratch[strobe.idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdEn;
      if (strobe.rdEn) rdData <= readMux;
    end
  end

endmodule

// File: rtl/memMapDecoder.sv
module memMapDecoder
  import memMapPkg::*;
#(
  parameter int                ROM_MIN_LOG2 = 12,
  parameter int                ROM_MAX_LOG2 = 19,
  parameter logic [ADDR_W-1:0] RAM_BASE     = 32'h0200_0000,
  parameter int                RAM_MIN_LOG2 = 18,
  parameter int                RAM_MAX_LOG2 = 22,
  parameter logic [ADDR_W-1:0] REG_BASE     = 32'h01F8_0000,
  parameter int                BLK_LOG2     = 6,
  parameter int                NUM_WIN      = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              selRom,
  output logic              selRam,
  output logic              selRegs,
  output logic              accessTrap,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  regStrobe_t strobe;
  logic romHit, ramHit, regHit, protOn, winAllowed;

  memMapCtrl uCtrl (
    .busValid   (busValid),
    .busWrite   (busWrite),
    .regIdx     (busAddr[IDX_W+1:2]),
    .romHit     (romHit),
    .ramHit     (ramHit),
    .regHit     (regHit),
    .protOn     (protOn),
    .winAllowed (winAllowed),
    .selRom     (selRom),
    .selRam     (selRam),
    .selRegs    (selRegs),
    .accessTrap (accessTrap),
    .strobe     (strobe)
  );

  memMapData #(
    .ROM_MIN_LOG2 (ROM_MIN_LOG2),
    .ROM_MAX_LOG2 (ROM_MAX_LOG2),
    .RAM_BASE     (RAM_BASE),
    .RAM_MIN_LOG2 (RAM_MIN_LOG2),
    .RAM_MAX_LOG2 (RAM_MAX_LOG2),
    .REG_BASE     (REG_BASE),
    .BLK_LOG2     (BLK_LOG2),
    .NUM_WIN      (NUM_WIN)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .strobe     (strobe),
    .romHit     (romHit),
    .ramHit     (ramHit),
    .regHit     (regHit),
    .protOn     (protOn),
    .winAllowed (winAllowed),
    .rdValid    (rdValid),
    .rdData     (rdData)
  );

endmodule

// File: rtl/memMapChecker.sv
module memMapChecker (
  input logic clk,
  input logic rstN,
  input logic busValid,
  input logic busWrite,
  input logic selRom,
  input logic selRam,
  input logic selRegs,
  input logic accessTrap,
  input logic rdValid
);

  assert_sel_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selRom, selRam, selRegs}));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> !(selRom || selRam || selRegs || accessTrap));

  assert_unmapped_trap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !selRom && !selRam && !selRegs) |-> accessTrap);

  assert_regs_no_trap_R4: assert property (@(posedge clk) disable iff (!rstN)
    selRegs |-> !accessTrap);

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && selRegs) |=> rdValid);

  assert_no_spurious_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite && selRegs) |=> !rdValid);

  assert_ram_read_no_trap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (selRam && !busWrite) |-> !accessTrap);

endmodule

bind memMapDecoder memMapChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .busWrite   (busWrite),
  .selRom     (selRom),
  .selRam     (selRam),
  .selRegs    (selRegs),
  .accessTrap (accessTrap),
  .rdValid    (rdValid)
);

// File: tb/tb_memMapDecoder.sv
`timescale 1ns/1ps
module tb_memMapDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        selRom, selRam, selRegs, accessTrap, rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  memMapDecoder dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .selRom(selRom), .selRam(selRam),
    .selRegs(selRegs), .accessTrap(accessTrap), .rdValid(rdValid), .rdData(rdData)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mCtrl, mCfg, mWait, mAcc0, mAcc1;
  logic [31:0] mScr [64];
  bit          pendValid;
  logic [31:0] pendData;
  string       pendTag;

  localparam longint RAM_LO = 64'h0200_0000;

  task automatic modelReset();
    mCtrl = 0; mCfg = 0; mWait = 0; mAcc0 = 0; mAcc1 = 0;
    for (int i = 0; i < 64; i++) mScr[i] = 0;
    pendValid = 0;
    pendData = 0;
    pendTag = "R11";
  endtask

  function automatic logic [31:0] modelRead(int idx);
    case (idx)
      0:       return mCtrl;
      4:       return mCfg;
      6:       return mWait;
      8:       return mAcc0;
      9:       return mAcc1;
      default: return mScr[idx];
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic checkRead();
    if (pendValid) begin
      chk(rdValid == 1'b1, "R6", {31'b0, rdValid}, 32'd1);
      chk(rdData == pendData, pendTag, rdData, pendData);
    end else begin
      chk(rdValid == 1'b0, "R6", {31'b0, rdValid}, 32'd0);
    end
  endtask

  task automatic access(input bit v, input bit w, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
    longint romSz, ramSz, addr, blk;
    bit eRom, eRam, eReg, viol, win0, win1;
    int idx;
    @(negedge clk);
    checkRead();
    busValid = v; busWrite = w; busAddr = a; busWdata = d;
    #1;
    addr  = longint'(a);
    romSz = 64'd4096 << mCfg[2:0];
    if (romSz > 64'd524288) romSz = 64'd524288;
    ramSz = 64'd262144 << mCfg[6:4];
    if (ramSz > 64'd4194304) ramSz = 64'd4194304;
    eRom = addr < romSz;
    eRam = (addr >= RAM_LO) && (addr < RAM_LO + ramSz);
    eReg = (addr >= 64'h01F8_0000) && (addr <= 64'h01F8_00FF);
    blk  = (addr - RAM_LO) / 64;
    win0 = (blk >= longint'(mAcc0[15:0])) && (blk <= longint'(mAcc0[31:16]));
    win1 = (blk >= longint'(mAcc1[15:0])) && (blk <= longint'(mAcc1[31:16]));
    viol = eRam && w && mCtrl[3] && !win0 && !win1;
    chk(selRom == (v && eRom), tag, {31'b0, selRom}, {31'b0, v && eRom});
    chk(selRam == (v && eRam), tag, {31'b0, selRam}, {31'b0, v && eRam});
    chk(selRegs == (v && eReg), tag, {31'b0, selRegs}, {31'b0, v && eReg});
    chk(accessTrap == (v && (!(eRom || eRam || eReg) || viol)), tag,
        {31'b0, accessTrap}, {31'b0, v && (!(eRom || eRam || eReg) || viol)});
    pendValid = 0;
    if (v && eReg) begin
      idx = int'(a[7:2]);
      if (!w) begin
        pendValid = 1;
        pendData  = modelRead(idx);
        pendTag   = tag;
      end else begin
        case (idx)
          0: mCtrl = d & 32'h0000_000B;
          4: mCfg  = d;
          6: mWait = d;
          8: mAcc0 = d;
          9: mAcc1 = d;
          default: mScr[idx] = d;
        endcase
      end
    end
  endtask

  task automatic regWr(input logic [7:0] off, input logic [31:0] d, input string tag);
    access(1, 1, 32'h01F8_0000 | {24'b0, off}, d, tag);
  endtask

  task automatic regRd(input logic [7:0] off, input string tag);
    access(1, 0, 32'h01F8_0000 | {24'b0, off}, 32'h0, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state, every implemented register and a scratch word read zero
    access(0, 0, 32'h0, 32'h0, "R11");
    regRd(8'h00, "R11"); regRd(8'h10, "R11"); regRd(8'h18, "R11");
    regRd(8'h20, "R11"); regRd(8'h24, "R11"); regRd(8'h44, "R11");

    // R3: reset spans
    access(1, 0, 32'h0000_0000, 0, "R3");
    access(1, 0, 32'h0000_0FFF, 0, "R3");
    access(1, 0, 32'h0000_1000, 0, "R3");
    access(1, 1, 32'h0200_0000, 0, "R3");
    access(1, 0, 32'h0203_FFFF, 0, "R3");
    access(1, 0, 32'h0204_0000, 0, "R3");

    // R5: gaps trap, idle is quiet
    access(1, 0, 32'h0100_0000, 0, "R5");
    access(1, 1, 32'h01F8_0100, 0, "R5");
    access(1, 0, 32'hFFFF_FFFC, 0, "R5");
    access(0, 1, 32'h0100_0000, 0, "R5");

    // R4: register window edges
    regRd(8'h00, "R4");
    regRd(8'hFC, "R4");
    access(1, 0, 32'h01F8_00FF, 0, "R4");

    // R1/R2: mid setting PSIZ=3 (32 KB), RSIZ=2 (1 MB)
    regWr(8'h10, 32'h0000_0023, "R8");
    access(1, 0, 32'h0000_7FFC, 0, "R1");
    access(1, 0, 32'h0000_8000, 0, "R1");
    access(1, 1, 32'h020F_FFFC, 0, "R2");
    access(1, 0, 32'h0210_0000, 0, "R2");
    // R1/R2: clamp with all-ones fields
    regWr(8'h10, 32'hFFFF_FFFF, "R8");
    regRd(8'h10, "R8");
    access(1, 0, 32'h0007_FFFC, 0, "R1");
    access(1, 0, 32'h0008_0000, 0, "R1");
    access(1, 0, 32'h023F_FFFF, 0, "R2");
    access(1, 1, 32'h0240_0000, 0, "R2");
    access(1, 0, 32'h01FF_FFFF, 0, "R2");

    // R7: control register masking
    regWr(8'h00, 32'hFFFF_FFFF, "R7");
    regRd(8'h00, "R7");
    regWr(8'h00, 32'h0000_0004, "R7");
    regRd(8'h00, "R7");

    // R8: full-width registers
    regWr(8'h18, 32'hA5A5_5A5A, "R8");
    regWr(8'h20, 32'h1234_5678, "R8");
    regWr(8'h24, 32'h9ABC_DEF0, "R8");
    regRd(8'h18, "R8"); regRd(8'h20, "R8"); regRd(8'h24, "R8");

    // R9: scratch words keep data, decoding unchanged
    regWr(8'h04, 32'hDEAD_BEEF, "R9");
    regWr(8'h40, 32'h0BAD_F00D, "R9");
    regWr(8'hFC, 32'hCAFE_0001, "R9");
    regWr(8'h14, 32'h0000_0000, "R9");
    regRd(8'h04, "R9"); regRd(8'h40, "R9"); regRd(8'hFC, "R9"); regRd(8'h10, "R9");
    access(1, 0, 32'h0007_FFFC, 0, "R9");
    access(1, 0, 32'h023F_FFFC, 0, "R9");

    // R10: protection windows
    regWr(8'h20, {16'h001F, 16'h0010}, "R10");
    regWr(8'h24, {16'h0100, 16'h0100}, "R10");
    access(1, 1, 32'h0200_0800, 0, "R10");   // protection still off
    regWr(8'h00, 32'h0000_0008, "R10");
    access(1, 1, 32'h0200_0400, 0, "R10");
    access(1, 1, 32'h0200_07FC, 0, "R10");
    access(1, 1, 32'h0200_0800, 0, "R10");
    access(1, 1, 32'h0200_03FC, 0, "R10");
    access(1, 1, 32'h0200_4000, 0, "R10");
    access(1, 1, 32'h0200_403F, 0, "R10");
    access(1, 1, 32'h0200_4040, 0, "R10");
    access(1, 0, 32'h0200_0800, 0, "R10");
    access(1, 1, 32'h0000_0100, 0, "R10");
    regWr(8'h00, 32'h0000_0003, "R10");
    access(1, 1, 32'h0200_0800, 0, "R10");

    // Mixed sweep against the model, including register reprogramming
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, base, a;
      r = $urandom;
      case (r[1:0])
        2'd0: base = 32'h0000_0000;
        2'd1: base = 32'h0200_0000;
        2'd2: base = 32'h01F8_0000;
        default: base = 32'h023F_0000;
      endcase
      a = base + (r[2] ? {12'b0, r[21:2]} : {24'b0, r[9:2], 2'b00});
      if (r[1:0] == 2'd2) a = 32'h01F8_0000 | {24'b0, r[9:2], 2'b00};
      access(r[31:30] != 2'b00, r[29], a, $urandom & (r[28] ? 32'h0000_FF7F : 32'hFFFF_FFFF), "R5");
    end

    access(0, 0, 32'h0, 32'h0, "R6");
    access(0, 0, 32'h0, 32'h0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule